// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital heart of a 16-bit successive-approximation converter. Two active-low strobes, a chip select (`sel_n`) and a read/convert line (`rd_cnv`), are merged with an OR. A conversion begins when that merged strobe falls, which happens on whichever of the two lines goes low last. The sequencer clears its approximation register and decides one bit per step, starting at the most significant bit. At each step it sets the trial bit and shows the trial word on `dac_word` to an external DAC. After a parameterised settling time it keeps or drops the bit according to a one-bit comparator input. When the last bit is decided, the result is loaded into an output latch in two's complement form, with the MSB inverted. `busy_n` is low for the whole conversion and rises in the same cycle the latch is loaded.

The latched result goes out on a 16-bit bus with an output enable. The bus is active only while chip select is low and read/convert is high. A lane-swap input exchanges the two bytes. Strobe falls during a conversion are ignored. If the merged strobe is still low when `busy_n` rises, the next conversion starts at once, with no acquisition gap.

The controller has five states. IDLE waits for a start. SET raises the trial bit. WAIT holds the trial word for `SETTLE` cycles. DECIDE samples the comparator. LOAD writes the result latch. The transitions are:
- IDLE→SET on a merged-strobe fall, or on a merged strobe still low in the cycle after LOAD.
- SET→WAIT always.
- WAIT→DECIDE when the settle count expires.
- DECIDE→SET while bits remain.
- DECIDE→LOAD after bit 0.
- LOAD→IDLE always.

Top module: `sar_seq_core`

## Requirements
- R1: A conversion starts on the clock edge where the merged strobe (`sel_n | rd_cnv`) is low and was high at the previous edge, whether `rd_cnv` or `sel_n` fell last. `busy_n` is low from the next cycle.
- R2: A merged-strobe fall while `busy_n` is low has no effect: the length and the result of the running conversion are unchanged, and no second conversion follows when the strobe is high at the end.
- R3: The latched result equals the input code with bit 15 inverted (two's complement), where the comparator input `cmp_hi`=1 means the input is at or above `dac_word`. `busy_n` stays low for exactly 16*(SETTLE+2)+1 cycles.
- R4: `busy_n` rises in the cycle the result latch is loaded. The latch does not change while `busy_n` stays high.
- R5: If the merged strobe is low in the cycle `busy_n` rises, `busy_n` is high for exactly one cycle and a new conversion starts.
- R6: `bus_oe` is 1 exactly when `sel_n`=0 and `rd_cnv`=1. While `bus_oe`=0, `bus_q` is all zeros.
- R7: With `lane_swap`=0, `bus_q` equals the latch. With `lane_swap`=1, `bus_q[15:8]` carries latch bits 7..0 and `bus_q[7:0]` carries latch bits 15..8.
- R8: The previous result stays readable on the bus during a conversion until the new result is loaded.
- R9: After reset, `busy_n`=1, the latch is 0 and `dac_word` is 0.
- R10: The first trial word after a conversion starts is 16'h8000, with only bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | Read (high) / convert (low) strobe |
| lane_swap | input | 1 | 1 = exchange the upper and lower bytes on the bus |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above `dac_word` |
| dac_word | output | 16 | Trial word to the DAC |
| busy_n | output | 1 | Low while a conversion runs |
| bus_q | output | 16 | Output data bus, zero when disabled |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The bench models the analog side as a compare of the trial word against a stored code. It converts the all-ones, all-zeros, mid-scale (16'h8000), one-below-mid-scale (16'h7FFF), single-LSB and mixed codes; the extreme codes separate a stuck keep/drop decision at either end of the register. Starts are driven both by a `rd_cnv` fall with `sel_n` held low and by a `sel_n` fall with `rd_cnv` already low, which tells apart a decoder that watches only one strobe. Separate runs inject a strobe fall during a conversion, hold the strobe low across the end of a conversion, and read mid-conversion with both lane settings. These show whether restart suppression, back-to-back starts, old-data visibility and byte placement are each handled correctly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SET    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_DECIDE = 3'd3,
        ST_LOAD   = 3'd4
    } step_state_t;

endpackage

// File: rtl/sar_strobe_dec.sv
// Merges the two active-low strobes and flags the high-to-low transition.
module sar_strobe_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rd_cnv,
    output logic strobe_low,
    output logic strobe_fall
);
    logic merged;
    logic merged_q;

    assign merged      = sel_n | rd_cnv;
    assign strobe_low  = ~merged;
    assign strobe_fall = merged_q & ~merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged_q <= 1'b1;
        end else begin
            merged_q <= merged;
        end
    end
endmodule

// File: rtl/sar_step_engine.sv
// Five-state bit-decision controller for the approximation register.
module sar_step_engine
    import sar_seq_pkg::*;
#(
    parameter int W      = 16,
    parameter int SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_fall,
    input  logic         strobe_low,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_word,
    output logic         busy_n,
    output logic         load_en,
    output logic [W-1:0] load_word
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam int CW = $clog2(SETTLE + 1) + 1;
    localparam logic [IW-1:0] TOP_IDX   = IW'(W - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(SETTLE - 1);

    step_state_t   state_q, state_d;
    logic [W-1:0]  sar_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (strobe_fall || (done_q && strobe_low)) state_d = ST_SET;
            ST_SET:    state_d = ST_WAIT;
            ST_WAIT:   if (cnt_q == WAIT_LAST) state_d = ST_DECIDE;
            ST_DECIDE: state_d = (idx_q == '0) ? ST_LOAD : ST_SET;
            ST_LOAD:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // register and flag updates per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q  <= '0;
            idx_q  <= TOP_IDX;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (state_d == ST_SET) begin
                        sar_q  <= '0;
                        idx_q  <= TOP_IDX;
                        busy_q <= 1'b0;
                    end
                end
                ST_SET: begin
                    sar_q[idx_q] <= 1'b1;
                    cnt_q        <= '0;
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_DECIDE: begin
                    if (!cmp_hi) sar_q[idx_q] <= 1'b0;
                    if (idx_q != '0) idx_q <= idx_q - 1'b1;
                end
                ST_LOAD: begin
                    busy_q <= 1'b1;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign dac_word  = sar_q;
    assign busy_n    = busy_q;
    assign load_en   = (state_q == ST_LOAD);
    assign load_word = {~sar_q[W-1], sar_q[W-2:0]};
endmodule

// File: rtl/sar_out_port.sv
// Result latch and output bus with enable and byte exchange.
module sar_out_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_word,
    input  logic         sel_n,
    input  logic         rd_cnv,
    input  logic         lane_swap,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    localparam int H = W / 2;

    logic [W-1:0] swapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load_en) begin
            latch_q <= load_word;
        end
    end

    assign swapped = {latch_q[H-1:0], latch_q[W-1:H]};
    assign bus_oe  = ~sel_n & rd_cnv;

    always_comb begin
        if (!bus_oe) begin
            bus_q = '0;
        end else if (lane_swap) begin
            bus_q = swapped;
        end else begin
            bus_q = latch_q;
        end
    end
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
    parameter int W      = 16,
    parameter int SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         rd_cnv,
    input  logic         lane_swap,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_word,
    output logic         busy_n,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    logic         strobe_low;
    logic         strobe_fall;
    logic         load_en;
    logic [W-1:0] load_word;
    logic [W-1:0] res_q;

    sar_strobe_dec dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .rd_cnv      (rd_cnv),
        .strobe_low  (strobe_low),
        .strobe_fall (strobe_fall)
    );

    sar_step_engine #(.W(W), .SETTLE(SETTLE)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_fall (strobe_fall),
        .strobe_low  (strobe_low),
        .cmp_hi      (cmp_hi),
        .dac_word    (dac_word),
        .busy_n      (busy_n),
        .load_en     (load_en),
        .load_word   (load_word)
    );

    sar_out_port #(.W(W)) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (load_word),
        .sel_n     (sel_n),
        .rd_cnv    (rd_cnv),
        .lane_swap (lane_swap),
        .latch_q   (res_q),
        .bus_q     (bus_q),
        .bus_oe    (bus_oe)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W      = 16,
    parameter int SETTLE = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_n,
    input logic         rd_cnv,
    input logic [W-1:0] dac_word,
    input logic         busy_n,
    input logic [W-1:0] bus_q,
    input logic         bus_oe,
    input logic [W-1:0] res_q
);
    localparam int CONV = W * (SETTLE + 2) + 1;
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!busy_n) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    // R6
    bus_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_q == '0));

    // R6
    sel_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !rd_cnv) |-> !bus_oe);

    // R4
    busy_hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && $past(busy_n)) |-> $stable(res_q));

    // R8
    busy_keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |=> (busy_n || $stable(res_q)));

    // R3
    conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == CONV));

    // R10
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |=> (dac_word == TOP_BIT));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_n) && !sel_n && !rd_cnv) |=> !busy_n);
endmodule

bind sar_seq_core sar_seq_chk #(.W(W), .SETTLE(SETTLE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .rd_cnv   (rd_cnv),
    .dac_word (dac_word),
    .busy_n   (busy_n),
    .bus_q    (bus_q),
    .bus_oe   (bus_oe),
    .res_q    (res_q)
);

// File: tb/sar_seq_core_tb.sv
module sar_seq_core_tb_top;
    localparam int CLK_P  = 10;
    localparam int W      = 16;
    localparam int SETTLE = 3;
    localparam int CONV   = W * (SETTLE + 2) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          rd_cnv = 1'b1;
    logic          lane_swap = 1'b0;
    logic          cmp_hi;
    logic [W-1:0]  dac_word;
    logic          busy_n;
    logic [W-1:0]  bus_q;
    logic          bus_oe;
    logic [W-1:0]  code_in = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    // behavioural analog side
    assign cmp_hi = (code_in >= dac_word);

    sar_seq_core #(.W(W), .SETTLE(SETTLE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .rd_cnv    (rd_cnv),
        .lane_swap (lane_swap),
        .cmp_hi    (cmp_hi),
        .dac_word  (dac_word),
        .busy_n    (busy_n),
        .bus_q     (bus_q),
        .bus_oe    (bus_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model: counts conversion cycles, holds the expected latch
    int          busy_left = 0;
    logic        exp_busy_n = 1'b1;
    logic [W-1:0] exp_latch = '0;
    bit          m_prev = 1'b1;
    bit          m_done = 1'b0;
    logic        exp_oe;
    logic [W-1:0] exp_bus;

    always @(posedge clk) begin
        bit cur;
        if (!rst_n) begin
            busy_left = 0; exp_busy_n = 1'b1; exp_latch = '0; m_prev = 1'b1; m_done = 1'b0;
        end else begin
            cur = sel_n | rd_cnv;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    exp_busy_n = 1'b1;
                    exp_latch  = code_in ^ 16'h8000;
                    m_done     = 1'b1;
                end
            end else begin
                if ((m_prev && !cur) || (m_done && !cur)) begin
                    busy_left  = CONV;
                    exp_busy_n = 1'b0;
                end
                m_done = 1'b0;
            end
            m_prev = cur;
        end
    end

    assign exp_oe  = !sel_n && rd_cnv;
    assign exp_bus = !exp_oe ? '0 :
                     (lane_swap ? {exp_latch[7:0], exp_latch[15:8]} : exp_latch);

    // per-clock comparison and run-length monitor
    int low_run = 0;
    int last_run = 0;
    bit prev_busy = 1'b1;
    bit arm_dac = 1'b0;

    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            chk("R4 busy_n vs model", busy_n, exp_busy_n);
            chk("R6 bus_oe vs model", bus_oe, exp_oe);
            chk("R7 bus_q vs model", bus_q, exp_bus);
            if (arm_dac) chk("R10 first trial word", dac_word, 16'h8000);
            arm_dac = prev_busy && !busy_n;
            if (!busy_n) low_run++;
            else if (low_run > 0) begin last_run = low_run; low_run = 0; end
            prev_busy = busy_n;
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #(CLK_P/4 + 1);
    endtask

    task automatic wait_level(input logic lvl);
        int n = 0;
        while (busy_n !== lvl && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        @(negedge clk);
        sel_n = 1'b0;
        settle();
        chk("R9 busy_n after reset", busy_n, 1'b1);
        chk("R9 latch after reset", bus_q, 16'h0000);
        chk("R9 dac after reset", dac_word, 16'h0000);

        // R1 start by rd_cnv fall, sel_n held low
        code_in = 16'h1234;
        @(negedge clk); rd_cnv = 1'b0;
        settle();
        chk("R6 bus off while converting strobe low", bus_oe, 1'b0);
        chk("R1 busy_n before edge", busy_n, 1'b1);
        @(negedge clk);
        settle();
        chk("R1 busy_n after rd_cnv fall", busy_n, 1'b0);
        @(negedge clk); rd_cnv = 1'b1;
        wait_level(1'b1);
        @(negedge clk);
        settle();
        chk("R3 result 1234", bus_q, 16'h9234);
        chk("R3 conversion length", last_run, CONV);
        lane_swap = 1'b1;
        settle();
        chk("R7 swapped lanes", bus_q, 16'h3492);
        lane_swap = 1'b0;

        // R1 start by sel_n fall with rd_cnv low, R8 read mid-conversion
        @(negedge clk); sel_n = 1'b1; rd_cnv = 1'b0; code_in = 16'hFFFF;
        settle();
        chk("R6 bus off with sel_n high", bus_q, 16'h0000);
        @(negedge clk); sel_n = 1'b0;
        @(negedge clk);
        settle();
        chk("R1 busy_n after sel_n fall", busy_n, 1'b0);
        @(negedge clk); sel_n = 1'b1; rd_cnv = 1'b1;
        ticks(10);
        sel_n = 1'b0;
        settle();
        chk("R8 old result during conversion", bus_q, 16'h9234);
        chk("R8 busy still low", busy_n, 1'b0);
        lane_swap = 1'b1;
        settle();
        chk("R8 old result swapped", bus_q, 16'h3492);
        lane_swap = 1'b0;
        @(negedge clk); sel_n = 1'b1;
        wait_level(1'b1);
        @(negedge clk); sel_n = 1'b0;
        settle();
        chk("R3 result FFFF", bus_q, 16'h7FFF);

        // R2 strobe fall during conversion ignored
        code_in = 16'h0000;
        @(negedge clk); rd_cnv = 1'b0;
        ticks(5); rd_cnv = 1'b1;
        ticks(5); rd_cnv = 1'b0;
        ticks(5); rd_cnv = 1'b1;
        wait_level(1'b1);
        @(negedge clk);
        settle();
        chk("R2 length unchanged", last_run, CONV);
        chk("R2 result 0000", bus_q, 16'h8000);
        ticks(5);
        settle();
        chk("R2 no second conversion", busy_n, 1'b1);

        // R5 strobe held low across the end
        code_in = 16'h8000;
        @(negedge clk); rd_cnv = 1'b0;
        @(negedge clk);
        wait_level(1'b1);
        code_in = 16'h7FFF;
        settle();
        chk("R5 busy high one cycle", busy_n, 1'b1);
        @(negedge clk);
        settle();
        chk("R5 immediate restart", busy_n, 1'b0);
        rd_cnv = 1'b1;
        settle();
        chk("R5 first result 8000 visible", bus_q, 16'h0000);
        wait_level(1'b1);
        @(negedge clk);
        settle();
        chk("R5 second result 7FFF", bus_q, 16'hFFFF);
        chk("R3 back-to-back length", last_run, CONV);

        // single LSB code, read swapped
        code_in = 16'h0001;
        @(negedge clk); rd_cnv = 1'b0;
        @(negedge clk); rd_cnv = 1'b1;
        wait_level(1'b1);
        @(negedge clk); lane_swap = 1'b1;
        settle();
        chk("R7 result 0001 swapped", bus_q, 16'h0180);
        lane_swap = 1'b0;
        settle();
        chk("R3 result 0001", bus_q, 16'h8001);

        ticks(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual=not finished expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule